// File: doc/BRIEF.md
# Boundary-Scan Pad Loopback Exerciser

This block sits on a bank of bidirectional pads and lets a test controller prove every pad's output and input path through a serial scan interface alone. Each pad owns three scan cells. One cell captures what the input buffer sees, one supplies the output data and one supplies the output enable. An external TAP controller (not part of this block) issues shift, capture and update strobes. The scan chain itself is the only way to load a drive pattern or read back a response.

A sequencer expects each pad to be walked through three steps in a fixed order: driven high, released, then driven low. A released pad floats to a weak pull-up. The expected capture is therefore 1, 1 and 0 for the three steps. An update arms the current step. The next capture judges every pad against that step's expected value, latches one mismatch flag per pad, and moves on to the next step. After the low step the sequencer wraps back to the high step.

Pads with no package pin take part in the same way: the loopback model, the capture and the mismatch flag all work for them. Only their external pin reading is tied low. A per-pad select can send the reference or differential input path to the capture cell in place of the pad itself.

Top module: `pad_loopback_exerciser`

States of the sequencer and their transitions:
- `SQ_LOAD_HIGH` goes to `SQ_ARMED_HIGH` on update.
- `SQ_ARMED_HIGH` goes to `SQ_LOAD_FLOAT` on capture.
- `SQ_LOAD_FLOAT` goes to `SQ_ARMED_FLOAT` on update.
- `SQ_ARMED_FLOAT` goes to `SQ_LOAD_LOW` on capture.
- `SQ_LOAD_LOW` goes to `SQ_ARMED_LOW` on update.
- `SQ_ARMED_LOW` goes to `SQ_LOAD_HIGH` on capture (wrap).

Any other strobe leaves the state unchanged. A capture in a LOAD state still samples the input cells.

## Requirements
- R1: After reset the following hold: every hold latch is 0, so `pad_oe` and `pad_drive` are 0; the scan chain is all zero; `mismatch` is 0; `step_code` is 0 (high step); and `armed` is 0.
- R2: The chain for pad p occupies bit 3p (input capture), bit 3p+1 (output data) and bit 3p+2 (output enable). A shift moves `scan_in` into the top bit and presents bit 0 on `scan_out`, so a word is loaded and read least significant bit first. Capture writes only the input-capture bits.
- R3: `pad_oe` and `pad_drive` change only on the cycle after an update strobe. Shifting leaves them untouched.
- R4: A pad with its enable at 1 takes its data value. A pad with its enable at 0 reads 1 through the pull-up.
- R5: With `use_ref[p]`=1, the capture cell of pad p samples `ref_in[p]`. With `use_ref[p]`=0, it samples the pad level.
- R6: The sequencer follows the states listed above. `step_code` reads 0 for high, 1 for released and 2 for low, and `armed` is 1 in the ARMED states.
- R7: A capture in an ARMED state sets `mismatch[p]` to 1 exactly when pad p's captured bit differs from the step's expected value (high 1, released 1, low 0), and clears it otherwise.
- R8: Unbonded pads (`BONDED_MASK` bit 0) are captured and judged like bonded ones. Their `pin_level` reads 0.
- R9: A capture in a LOAD state loads the input-capture cells, but changes neither `mismatch` nor the step.
- R10: When strobes coincide, capture wins over update and update wins over shift. Only the winning strobe takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shift_en | input | 1 | Shift the chain one bit toward `scan_out` |
| capture_en | input | 1 | Load input-capture cells and judge an armed step |
| update_en | input | 1 | Copy data and enable cells into the pad hold latches |
| scan_in | input | 1 | Serial data into the top of the chain |
| use_ref | input | NUM_PADS | Per-pad select of the reference input path |
| ref_in | input | NUM_PADS | Per-pad reference or differential input value |
| scan_out | output | 1 | Serial data from bit 0 of the chain |
| pad_drive | output | NUM_PADS | Held output data per pad |
| pad_oe | output | NUM_PADS | Held output enable per pad |
| pin_level | output | NUM_PADS | Pad level at the package pin (0 when unbonded) |
| mismatch | output | NUM_PADS | Per-pad result of the last armed capture |
| step_code | output | 2 | Current step: 0 high, 1 released, 2 low |
| armed | output | 1 | Pads updated for the current step, awaiting capture |

## Verification
The bench builds the block with `NUM_PADS`=4 and `BONDED_MASK`=4'b0111. The resulting 12-bit chain is short enough that every shifted-out word can be compared bit for bit, with an echo of each loaded pattern. Leaving pad 3 unbonded puts the case of a pad with no pin inside every step. One deliberately wrong drive in the high step, and a reference-path capture in the released step, each show a mismatch flag on a single pad. The strobe-collision cases are run at the wrap from the low step back to the high step.

// File: rtl/plx_pkg.sv
`timescale 1ns/1ps
package plx_pkg;

    localparam int CELLS_PER_PAD = 3;
    localparam int CELL_CAP      = 0;
    localparam int CELL_DATA     = 1;
    localparam int CELL_EN       = 2;

    typedef enum logic [1:0] {
        STEP_HIGH  = 2'd0,
        STEP_FLOAT = 2'd1,
        STEP_LOW   = 2'd2
    } step_e;

    typedef enum logic [2:0] {
        SQ_LOAD_HIGH,
        SQ_ARMED_HIGH,
        SQ_LOAD_FLOAT,
        SQ_ARMED_FLOAT,
        SQ_LOAD_LOW,
        SQ_ARMED_LOW
    } seq_state_e;

    // Value the input cell must see in a given step; released pads pull up.
    function automatic logic step_expect(step_e s);
        return (s != STEP_LOW);
    endfunction

endpackage

// File: rtl/plx_pad_cell.sv
`timescale 1ns/1ps
module plx_pad_cell #(
    parameter bit BONDED = 1'b1
) (
    input  logic drv_data,
    input  logic drv_en,
    input  logic use_ref,
    input  logic ref_in,
    output logic pad_level,
    output logic pin_level,
    output logic cap_bit
);

    // Loopback model: driven value when enabled, weak pull-up when released.
    always_comb begin
        pad_level = drv_en ? drv_data : 1'b1;
        cap_bit   = use_ref ? ref_in : pad_level;
    end

    generate
        if (BONDED) begin : g_bonded
            always_comb pin_level = pad_level;
        end else begin : g_unbonded
            always_comb pin_level = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/plx_scan_chain.sv
`timescale 1ns/1ps
module plx_scan_chain
    import plx_pkg::*;
#(
    parameter int NUM_PADS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                do_shift,
    input  logic                do_capture,
    input  logic                do_update,
    input  logic                scan_in,
    input  logic [NUM_PADS-1:0] cap_bits,
    output logic                scan_out,
    output logic [NUM_PADS-1:0] drv_data,
    output logic [NUM_PADS-1:0] drv_en
);

    localparam int CHAIN_LEN = NUM_PADS * CELLS_PER_PAD;

    logic [CHAIN_LEN-1:0] shreg;
    logic [CHAIN_LEN-1:0] shreg_nxt;

    always_comb begin
        shreg_nxt = shreg;
        if (do_capture) begin
            for (int p = 0; p < NUM_PADS; p++) begin
                shreg_nxt[p*CELLS_PER_PAD + CELL_CAP] = cap_bits[p];
            end
        end else if (do_shift) begin
            shreg_nxt = {scan_in, shreg[CHAIN_LEN-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= shreg_nxt;
    end

    always_comb scan_out = shreg[0];

    generate
        for (genvar p = 0; p < NUM_PADS; p++) begin : g_hold
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    drv_data[p] <= 1'b0;
                    drv_en[p]   <= 1'b0;
                end else if (do_update) begin
                    drv_data[p] <= shreg[p*CELLS_PER_PAD + CELL_DATA];
                    drv_en[p]   <= shreg[p*CELLS_PER_PAD + CELL_EN];
                end
            end
        end
    endgenerate

    // R2: serial input enters the far end of the chain
    a_r2_serial_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (do_shift && !do_capture) |=> (shreg[CHAIN_LEN-1] == $past(scan_in)));

endmodule

// File: rtl/plx_sequencer.sv
`timescale 1ns/1ps
module plx_sequencer
    import plx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cap_go,
    input  logic  upd_go,
    output step_e step,
    output logic  armed,
    output logic  judge
);

    seq_state_e state;
    seq_state_e state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_LOAD_HIGH;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            SQ_LOAD_HIGH:   if (upd_go) state_nxt = SQ_ARMED_HIGH;
            SQ_ARMED_HIGH:  if (cap_go) state_nxt = SQ_LOAD_FLOAT;
            SQ_LOAD_FLOAT:  if (upd_go) state_nxt = SQ_ARMED_FLOAT;
            SQ_ARMED_FLOAT: if (cap_go) state_nxt = SQ_LOAD_LOW;
            SQ_LOAD_LOW:    if (upd_go) state_nxt = SQ_ARMED_LOW;
            SQ_ARMED_LOW:   if (cap_go) state_nxt = SQ_LOAD_HIGH;
            default:        state_nxt = SQ_LOAD_HIGH;
        endcase
    end

    always_comb begin
        step  = STEP_HIGH;
        armed = 1'b0;
        unique case (state)
            SQ_LOAD_HIGH:   begin step = STEP_HIGH;  armed = 1'b0; end
            SQ_ARMED_HIGH:  begin step = STEP_HIGH;  armed = 1'b1; end
            SQ_LOAD_FLOAT:  begin step = STEP_FLOAT; armed = 1'b0; end
            SQ_ARMED_FLOAT: begin step = STEP_FLOAT; armed = 1'b1; end
            SQ_LOAD_LOW:    begin step = STEP_LOW;   armed = 1'b0; end
            SQ_ARMED_LOW:   begin step = STEP_LOW;   armed = 1'b1; end
            default:        begin step = STEP_HIGH;  armed = 1'b0; end
        endcase
        judge = cap_go && armed;
    end

    // R6: update arms a loaded step
    a_r6_arm_on_update: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_go && !cap_go && !armed) |=> armed);

    // R6: capture of an armed step disarms and advances
    a_r6_advance_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_go && armed) |=> (!armed && step != $past(step)));

    // R9: capture in a load state keeps the step
    a_r9_load_capture_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_go && !armed) |=> (step == $past(step)));

endmodule

// File: rtl/pad_loopback_exerciser.sv
`timescale 1ns/1ps
module pad_loopback_exerciser
    import plx_pkg::*;
#(
    parameter int                NUM_PADS    = 8,
    parameter logic [NUM_PADS-1:0] BONDED_MASK = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic                capture_en,
    input  logic                update_en,
    input  logic                scan_in,
    input  logic [NUM_PADS-1:0] use_ref,
    input  logic [NUM_PADS-1:0] ref_in,
    output logic                scan_out,
    output logic [NUM_PADS-1:0] pad_drive,
    output logic [NUM_PADS-1:0] pad_oe,
    output logic [NUM_PADS-1:0] pin_level,
    output logic [NUM_PADS-1:0] mismatch,
    output logic [1:0]          step_code,
    output logic                armed
);

    logic                cap_go;
    logic                upd_go;
    logic                sh_go;
    logic                judge;
    step_e               step;
    logic [NUM_PADS-1:0] pad_level;
    logic [NUM_PADS-1:0] cap_bits;

    // Strobe priority: capture, then update, then shift.
    always_comb begin
        cap_go = capture_en;
        upd_go = update_en && !capture_en;
        sh_go  = shift_en && !capture_en && !update_en;
    end

    plx_sequencer u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_go (cap_go),
        .upd_go (upd_go),
        .step   (step),
        .armed  (armed),
        .judge  (judge)
    );

    plx_scan_chain #(.NUM_PADS(NUM_PADS)) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .do_shift   (sh_go),
        .do_capture (cap_go),
        .do_update  (upd_go),
        .scan_in    (scan_in),
        .cap_bits   (cap_bits),
        .scan_out   (scan_out),
        .drv_data   (pad_drive),
        .drv_en     (pad_oe)
    );

    generate
        for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
            plx_pad_cell #(.BONDED(BONDED_MASK[p])) u_pad (
                .drv_data  (pad_drive[p]),
                .drv_en    (pad_oe[p]),
                .use_ref   (use_ref[p]),
                .ref_in    (ref_in[p]),
                .pad_level (pad_level[p]),
                .pin_level (pin_level[p]),
                .cap_bit   (cap_bits[p])
            );

            // R4: a released pad on the direct path is seen as high
            a_r4_release_reads_high: assert property (@(posedge clk) disable iff (!rst_n)
                (!pad_oe[p] && !use_ref[p]) |-> cap_bits[p]);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     mismatch <= '0;
        else if (judge) mismatch <= cap_bits ^ {NUM_PADS{step_expect(step)}};
    end

    always_comb step_code = step;

    // R3: pad drive is frozen unless an update wins
    a_r3_pads_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_go |=> ($stable(pad_oe) && $stable(pad_drive)));

    // R10: a capture strobe suppresses a coinciding update
    a_r10_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
        capture_en |=> $stable(pad_oe));

endmodule

// File: tb/pad_loopback_exerciser_test.sv
`timescale 1ns/1ps
module pad_loopback_exerciser_test;

    localparam int N = 4;
    localparam int L = 3 * N;
    localparam logic [N-1:0] BMASK = 4'b0111;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shift_en = 1'b0;
    logic         capture_en = 1'b0;
    logic         update_en = 1'b0;
    logic         scan_in = 1'b0;
    logic [N-1:0] use_ref = '0;
    logic [N-1:0] ref_in = '0;
    logic         scan_out;
    logic [N-1:0] pad_drive;
    logic [N-1:0] pad_oe;
    logic [N-1:0] pin_level;
    logic [N-1:0] mismatch;
    logic [1:0]   step_code;
    logic         armed;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pad_loopback_exerciser #(.NUM_PADS(N), .BONDED_MASK(BMASK)) uut (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .capture_en(capture_en),
        .update_en(update_en), .scan_in(scan_in), .use_ref(use_ref), .ref_in(ref_in),
        .scan_out(scan_out), .pad_drive(pad_drive), .pad_oe(pad_oe),
        .pin_level(pin_level), .mismatch(mismatch), .step_code(step_code), .armed(armed)
    );

    function automatic logic [L-1:0] make_pat(input logic [N-1:0] d, input logic [N-1:0] en);
        logic [L-1:0] w = '0;
        for (int p = 0; p < N; p++) begin
            w[3*p+1] = d[p];
            w[3*p+2] = en[p];
        end
        return w;
    endfunction

    function automatic logic [L-1:0] with_caps(input logic [L-1:0] w, input logic [N-1:0] c);
        logic [L-1:0] r = w;
        for (int p = 0; p < N; p++) r[3*p] = c[p];
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic s, input logic u, input logic c, input logic si);
        @(negedge clk);
        shift_en = s; update_en = u; capture_en = c; scan_in = si;
        @(negedge clk);
        shift_en = 1'b0; update_en = 1'b0; capture_en = 1'b0; scan_in = 1'b0;
    endtask

    task automatic shift_word(input logic [L-1:0] din, output logic [L-1:0] dout);
        for (int i = 0; i < L; i++) begin
            @(negedge clk);
            scan_in = din[i];
            shift_en = 1'b1;
            dout[i] = scan_out;
        end
        @(negedge clk);
        shift_en = 1'b0;
        scan_in = 1'b0;
    endtask

    logic [L-1:0] pat_high, pat_float, pat_low, dout;

    task automatic t_reset();
        check("R1 pad_oe", pad_oe, 0);
        check("R1 pad_drive", pad_drive, 0);
        check("R1 mismatch", mismatch, 0);
        check("R1 step_code", step_code, 0);
        check("R1 armed", armed, 0);
        check("R1 scan_out", scan_out, 0);
        check("R8 pin_level released", pin_level, 4'b0111);
    endtask

    task automatic t_load_capture();
        strobe(1'b0, 1'b0, 1'b1, 1'b0);
        check("R9 step kept", step_code, 0);
        check("R9 still load", armed, 0);
        check("R9 mismatch kept", mismatch, 0);
        shift_word(pat_high, dout);
        check("R9 captured word", dout, with_caps('0, 4'b1111));
    endtask

    task automatic t_high_step();
        strobe(1'b0, 1'b1, 1'b0, 1'b0);
        check("R6 armed high", armed, 1);
        check("R4 pad_oe high", pad_oe, 4'b1111);
        check("R4 pad_drive high", pad_drive, 4'b1101);
        check("R8 pin_level high", pin_level, 4'b0101);
        strobe(1'b0, 1'b0, 1'b1, 1'b0);
        check("R6 step to float", step_code, 1);
        check("R7 high mismatch", mismatch, 4'b0010);
        shift_word(pat_float, dout);
        check("R2 high echo", dout, with_caps(pat_high, 4'b1101));
        check("R3 oe frozen after shift", pad_oe, 4'b1111);
        check("R3 drive frozen after shift", pad_drive, 4'b1101);
    endtask

    task automatic t_float_step();
        @(negedge clk);
        use_ref = 4'b0100; ref_in = 4'b0000;
        strobe(1'b0, 1'b1, 1'b0, 1'b0);
        check("R3 oe after update", pad_oe, 4'b0000);
        check("R8 pin_level float", pin_level, 4'b0111);
        strobe(1'b0, 1'b0, 1'b1, 1'b0);
        check("R6 step to low", step_code, 2);
        check("R5 R7 float mismatch", mismatch, 4'b0100);
        shift_word(pat_low, dout);
        check("R5 float echo", dout, with_caps(pat_float, 4'b1011));
        @(negedge clk);
        use_ref = 4'b0000;
    endtask

    task automatic t_low_and_priority();
        strobe(1'b0, 1'b1, 1'b0, 1'b0);
        check("R4 pad_oe low", pad_oe, 4'b1111);
        check("R4 pin_level low", pin_level, 4'b0000);
        strobe(1'b1, 1'b1, 1'b1, 1'b1);
        check("R10 capture wins step", step_code, 0);
        check("R10 capture wins armed", armed, 0);
        check("R7 low mismatch", mismatch, 4'b0000);
        check("R10 no update", pad_oe, 4'b1111);
        shift_word(pat_high, dout);
        check("R10 no shift", dout, with_caps(pat_low, 4'b0000));
        strobe(1'b1, 1'b1, 1'b0, 1'b1);
        check("R10 update wins", armed, 1);
        check("R10 high reloaded", pad_drive, 4'b1101);
        shift_word(pat_high, dout);
        check("R10 update not shifted", dout, with_caps(pat_high, 4'b0000));
        strobe(1'b0, 1'b0, 1'b1, 1'b0);
        check("R6 wrap high judged", mismatch, 4'b0010);
        check("R6 wrap to float", step_code, 1);
    endtask

    initial begin
        pat_high  = make_pat(4'b1101, 4'b1111);
        pat_float = make_pat(4'b1111, 4'b0000);
        pat_low   = make_pat(4'b0000, 4'b1111);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_capture();
        t_high_step();
        t_float_step();
        t_low_and_priority();
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule